// File: doc/BRIEF.md
# Three-Plane Graphics Write ALU

This block sits between a byte-wide CPU bus and three bit-plane graphics memories. With it, one CPU access reaches all three planes. A read fetches the byte at the addressed location from every plane at once and holds the three bytes in read latches. The CPU then gets back a colour-match mask rather than raw plane data.

A write applies a logic operation to each plane's latched byte, using the CPU byte as the bit mask. Each plane has its own operation. Instead of that, a write can also store latched bytes back into the planes, or copy one plane's latched byte into another plane. The usual use is read-modify-write: read an address, which loads the latches, then write the same address.

A mode bit steers CPU accesses. When it is set, accesses go to the planes. When it is clear, they go to ordinary main memory: the block then only raises a select output and leaves the planes and the latches alone.

Top module: `gpa_top`

## Requirements
- R1: After reset, both configuration registers are zero. Plane access is therefore off, so a strobe drives `main_sel`. `acc_rvalid`, `pl_re` and `pl_we` are all low, and every read latch holds zero.
- R2: Operation register (`cfg_sel`=0) layout: plane 0 takes its operation from bits 1:0, plane 1 from bits 3:2 and plane 2 from bits 5:4. Control register (`cfg_sel`=1) layout: bit 7 is plane-access enable, bits 5:4 are the data-path select, and bit p of bits 2:0 is the compare reference for plane p. A register loads on the clock edge at which `cfg_we` is high.
- R3: With data-path select 00, a write gives each plane an operation on its latched byte L, using the CPU byte D: code 00 gives L & ~D, 01 gives L | D, 10 gives L ^ D. Code 11 leaves that plane's location unwritten.
- R4: With data-path select 01, a write stores each plane's own latched byte into that plane at the addressed location.
- R5: With data-path select 10, a write stores plane 1's latched byte into plane 0 only.
- R6: With data-path select 11, a write stores plane 0's latched byte into plane 1 only.
- R7: A plane read raises `pl_re` in the strobe cycle. All three read latches load on the second rising edge after the strobe. `acc_rvalid` is high for exactly the one cycle after that edge.
- R8: While `acc_rvalid` is high, bit i of `acc_rdata` is 1 exactly when bit i of every plane's latch equals that plane's compare reference bit.
- R9: While plane access is off, a strobe asserts `main_sel` in the same cycle. It raises neither `pl_re` nor `pl_we`, and it leaves the plane memories and the read latches unchanged.
- R10: A plane write drives `pl_we` and `pl_wdata` in the strobe cycle only. The plane memory holds the new byte from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the operation register, 1 selects the control register |
| cfg_wdata | input | 8 | Configuration write data |
| acc_stb | input | 1 | CPU access strobe, one cycle per access |
| acc_we | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | ADDR_W | CPU access address |
| acc_wdata | input | 8 | CPU write byte (operation mask) |
| acc_rdata | output | 8 | Colour-match mask |
| acc_rvalid | output | 1 | `acc_rdata` is valid for this cycle |
| main_sel | output | 1 | The current access goes to main memory |
| pl_re | output | 1 | Read request to all three planes |
| pl_we | output | 3 | Per-plane write enable, bit p for plane p |
| pl_addr | output | ADDR_W | Plane memory address |
| pl_wdata | output | 24 | Plane write data, byte p for plane p |
| pl_rdata | input | 24 | Plane read data one cycle after `pl_re`, byte p for plane p |

## Verification
The assertions assume the CPU side obeys one rule: no plane access is strobed while a plane read is still in flight, which is the cycle right after a read strobe. The bench waits two idle cycles after every read, so it never breaks that rule. The bench also never writes the configuration registers while a read result is pending. This keeps the compare reference fixed between the read strobe and the cycle in which `acc_rdata` is valid. The plane memories are synchronous RAMs in the bench. They return read data one cycle after `pl_re`, which is the latency the read-latch timing relies on.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

  localparam int BYTE_W  = 8;
  localparam int NPLANES = 3;
  localparam int PLANE_BUS_W = BYTE_W * NPLANES;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'b00,
    OP_SET   = 2'b01,
    OP_FLIP  = 2'b10,
    OP_KEEP  = 2'b11
  } plane_op_e;

  typedef enum logic [1:0] {
    DP_LOGIC    = 2'b00,
    DP_RESTORE  = 2'b01,
    DP_P1_TO_P0 = 2'b10,
    DP_P0_TO_P1 = 2'b11
  } datapath_e;

  // Logic operation of one plane: latched byte combined with the CPU mask.
  function automatic logic [BYTE_W-1:0] plane_alu(
    input logic [BYTE_W-1:0] held,
    input logic [BYTE_W-1:0] mask,
    input plane_op_e         op
  );
    logic [BYTE_W-1:0] r;
    unique case (op)
      OP_CLEAR: r = held & ~mask;
      OP_SET:   r = held | mask;
      OP_FLIP:  r = held ^ mask;
      default:  r = held;
    endcase
    return r;
  endfunction

  // Colour match: a bit is 1 where every plane agrees with its reference.
  function automatic logic [BYTE_W-1:0] colour_match(
    input logic [PLANE_BUS_W-1:0] planes,
    input logic [NPLANES-1:0]     refbits
  );
    logic [BYTE_W-1:0] m;
    m = '1;
    for (int p = 0; p < NPLANES; p++) begin
      m &= ~(planes[p*BYTE_W +: BYTE_W] ^ {BYTE_W{refbits[p]}});
    end
    return m;
  endfunction

endpackage

// File: rtl/gpa_cfg_regs.sv
module gpa_cfg_regs
  import gpa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [BYTE_W-1:0]  cfg_wdata,
  output logic [2*NPLANES-1:0] ops_o,
  output datapath_e          path_o,
  output logic               gfx_en_o,
  output logic [NPLANES-1:0] ref_o
);

  localparam int OPS_W = 2 * NPLANES;

  logic [OPS_W-1:0]   ops_q;
  datapath_e          path_q;
  logic               gfx_q;
  logic [NPLANES-1:0] ref_q;

  logic ld_ops, ld_ctl;
  assign ld_ops = cfg_we && !cfg_sel;
  assign ld_ctl = cfg_we &&  cfg_sel;

  logic cfg_unused;
  assign cfg_unused = ^{cfg_wdata[7:6], cfg_wdata[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops_q  <= '0;
      path_q <= DP_LOGIC;
      gfx_q  <= 1'b0;
      ref_q  <= '0;
    end else begin
      if (ld_ops) ops_q <= cfg_wdata[OPS_W-1:0];
      if (ld_ctl) begin
        gfx_q  <= cfg_wdata[7];
        path_q <= datapath_e'(cfg_wdata[5:4]);
        ref_q  <= cfg_wdata[NPLANES-1:0];
      end
    end
  end

  assign ops_o    = ops_q;
  assign path_o   = path_q;
  assign gfx_en_o = gfx_q;
  assign ref_o    = ref_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable({ops_q, path_q, gfx_q, ref_q})); // R2

endmodule

// File: rtl/gpa_read_latch.sv
module gpa_read_latch
  import gpa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_issue,
  input  logic [PLANE_BUS_W-1:0] pl_rdata,
  output logic [PLANE_BUS_W-1:0] latch_o,
  output logic                   pend_o,
  output logic                   valid_o
);

  logic [PLANE_BUS_W-1:0] latch_q;
  logic pend_q, valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= rd_issue;
      valid_q <= pend_q;
      if (pend_q) latch_q <= pl_rdata;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = pend_q;
  assign valid_o = valid_q;

  AST_LATCH_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(latch_q)); // R9
  AST_PEND_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> pend_q); // R7
  AST_VALID_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> valid_q); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R7

endmodule

// File: rtl/gpa_write_mux.sv
module gpa_write_mux
  import gpa_pkg::*;
(
  input  logic                   wr_go,
  input  datapath_e              path,
  input  logic [2*NPLANES-1:0]   ops,
  input  logic [BYTE_W-1:0]      cpu_byte,
  input  logic [PLANE_BUS_W-1:0] latch,
  output logic [NPLANES-1:0]     we_o,
  output logic [PLANE_BUS_W-1:0] wdata_o
);

  logic [BYTE_W-1:0] held0, held1;
  assign held0 = latch[0 +: BYTE_W];
  assign held1 = latch[BYTE_W +: BYTE_W];

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    plane_op_e         op_p;
    logic [BYTE_W-1:0] held_p;
    logic [BYTE_W-1:0] data_p;
    logic              en_p;

    assign op_p   = plane_op_e'(ops[2*p +: 2]);
    assign held_p = latch[p*BYTE_W +: BYTE_W];

    always_comb begin
      data_p = held_p;
      en_p   = 1'b0;
      unique case (path)
        DP_LOGIC: begin
          data_p = plane_alu(held_p, cpu_byte, op_p);
          en_p   = (op_p != OP_KEEP);
        end
        DP_RESTORE: begin
          data_p = held_p;
          en_p   = 1'b1;
        end
        DP_P1_TO_P0: begin
          data_p = held1;
          en_p   = (p == 0);
        end
        default: begin
          data_p = held0;
          en_p   = (p == 1);
        end
      endcase
    end

    assign we_o[p]                    = wr_go && en_p;
    assign wdata_o[p*BYTE_W +: BYTE_W] = data_p;
  end

endmodule

// File: rtl/gpa_top.sv
module gpa_top
  import gpa_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [7:0]             cfg_wdata,
  input  logic                   acc_stb,
  input  logic                   acc_we,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [7:0]             acc_wdata,
  output logic [7:0]             acc_rdata,
  output logic                   acc_rvalid,
  output logic                   main_sel,
  output logic                   pl_re,
  output logic [2:0]             pl_we,
  output logic [ADDR_W-1:0]      pl_addr,
  output logic [23:0]            pl_wdata,
  input  logic [23:0]            pl_rdata
);

  logic [2*NPLANES-1:0]   ops;
  datapath_e              path;
  logic                   gfx_en;
  logic [NPLANES-1:0]     refbits;
  logic [PLANE_BUS_W-1:0] latch;
  logic                   rd_pend;

  // Named access events
  logic gfx_hit, rd_go, wr_go, main_hit;
  assign gfx_hit  = acc_stb &&  gfx_en;
  assign main_hit = acc_stb && !gfx_en;
  assign rd_go    = gfx_hit && !acc_we;
  assign wr_go    = gfx_hit &&  acc_we;

  gpa_cfg_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ops_o     (ops),
    .path_o    (path),
    .gfx_en_o  (gfx_en),
    .ref_o     (refbits)
  );

  gpa_read_latch i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_go),
    .pl_rdata (pl_rdata),
    .latch_o  (latch),
    .pend_o   (rd_pend),
    .valid_o  (acc_rvalid)
  );

  gpa_write_mux i_wmux (
    .wr_go    (wr_go),
    .path     (path),
    .ops      (ops),
    .cpu_byte (acc_wdata),
    .latch    (latch),
    .we_o     (pl_we),
    .wdata_o  (pl_wdata)
  );

  assign main_sel  = main_hit;
  assign pl_re     = rd_go;
  assign pl_addr   = acc_addr;
  assign acc_rdata = colour_match(latch, refbits);

  AST_NO_ACCESS_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !(acc_stb && gfx_en)); // R7
  AST_WE_NEEDS_WRITE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_we != '0) |-> (acc_stb && acc_we && !main_sel)); // R10
  AST_MAIN_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    main_sel |-> (!pl_re && pl_we == '0)); // R9
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pl_re |-> (pl_we == '0)); // R7
  AST_COPY_TO_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (path == DP_P1_TO_P0 && pl_we != '0) |-> (pl_we == 3'b001 && pl_wdata[7:0] == latch[15:8])); // R5
  AST_COPY_TO_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (path == DP_P0_TO_P1 && pl_we != '0) |-> (pl_we == 3'b010 && pl_wdata[15:8] == latch[7:0])); // R6
  AST_RESTORE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (path == DP_RESTORE && acc_stb && acc_we && gfx_en) |-> ($countones(pl_we) == 3 && pl_wdata == latch)); // R4

endmodule

// File: tb/test_gpa_top.sv
`timescale 1ns/1ps
module test_gpa_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_sel;
  logic [7:0] cfg_wdata;
  logic acc_stb, acc_we;
  logic [AW-1:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata;
  logic acc_rvalid, main_sel, pl_re;
  logic [2:0] pl_we;
  logic [AW-1:0] pl_addr;
  logic [23:0] pl_wdata, pl_rdata;

  always #2 clk = ~clk;

  gpa_top #(.ADDR_W(AW)) i_gpa_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_stb(acc_stb), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .main_sel(main_sel),
    .pl_re(pl_re), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
  );

  // Plane memories: synchronous RAMs
  logic [7:0] ram [3][DEPTH];
  always @(posedge clk) begin
    for (int p = 0; p < 3; p++) begin
      if (pl_we[p]) ram[p][pl_addr] <= pl_wdata[p*8 +: 8];
      if (pl_re)    pl_rdata[p*8 +: 8] <= ram[p][pl_addr];
    end
  end

  // Reference model
  logic [7:0] rm [3][DEPTH];
  logic [7:0] rl [3];
  logic [7:0] snap [3];
  int   m_ops [3];
  int   m_path;
  bit   m_gfx;
  bit   m_ref [3];
  bit   m_pend, m_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mdl_match();
    int m = 0;
    for (int i = 0; i < 8; i++) begin
      bit all = 1;
      for (int p = 0; p < 3; p++) if (rl[p][i] != m_ref[p]) all = 0;
      if (all) m |= (1 << i);
    end
    return m;
  endfunction

  function automatic int mdl_we_mask();
    case (m_path)
      0: begin
        int k = 0;
        for (int p = 0; p < 3; p++) if (m_ops[p] != 3) k |= (1 << p);
        return k;
      end
      1: return 7;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++) begin rl[p] = 0; m_ops[p] = 0; m_ref[p] = 0; end
      m_path = 0; m_gfx = 0; m_pend = 0; m_valid = 0;
    end else begin
      if (acc_stb && m_gfx && acc_we) begin
        for (int p = 0; p < 3; p++) begin
          case (m_path)
            0: case (m_ops[p])
                 0: rm[p][acc_addr] = rl[p] & ~acc_wdata;
                 1: rm[p][acc_addr] = rl[p] | acc_wdata;
                 2: rm[p][acc_addr] = rl[p] ^ acc_wdata;
                 default: ;
               endcase
            1: rm[p][acc_addr] = rl[p];
            2: if (p == 0) rm[0][acc_addr] = rl[1];
            default: if (p == 1) rm[1][acc_addr] = rl[0];
          endcase
        end
      end
      m_valid = m_pend;
      if (m_pend) for (int p = 0; p < 3; p++) rl[p] = snap[p];
      m_pend = 0;
      if (acc_stb && m_gfx && !acc_we) begin
        for (int p = 0; p < 3; p++) snap[p] = rm[p][acc_addr];
        m_pend = 1;
      end
      if (cfg_we && !cfg_sel)
        for (int p = 0; p < 3; p++) m_ops[p] = (cfg_wdata >> (2*p)) & 3;
      if (cfg_we && cfg_sel) begin
        m_gfx  = cfg_wdata[7];
        m_path = (cfg_wdata >> 4) & 3;
        for (int p = 0; p < 3; p++) m_ref[p] = cfg_wdata[p];
      end
    end
  end

  // Cycle-by-cycle comparison, half a period after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit same = 1;
      check(acc_rvalid == m_valid, "R7", acc_rvalid, m_valid);
      if (m_valid) check(acc_rdata == mdl_match(), "R8", acc_rdata, mdl_match());
      check(main_sel == (acc_stb && !m_gfx), "R9", main_sel, acc_stb && !m_gfx);
      if (acc_stb && !m_gfx) check(!pl_re && pl_we == 0, "R9", {pl_re, pl_we}, 0);
      if (acc_stb && m_gfx && acc_we)
        check(pl_we == mdl_we_mask(), "R10", pl_we, mdl_we_mask());
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < DEPTH; a++)
          if (ram[p][a] !== rm[p][a]) same = 0;
      check(same, cur_req, same, 1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cfg(input bit sel, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    acc_stb = 1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_stb = 0;
    if (!we) idle(2);
  endtask

  task automatic round(input int path, input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      cfg(0, 8'($urandom));
      cfg(1, {1'b1, 1'b0, 2'(path), 1'b0, 3'($urandom)});
      access(0, a, 8'h00);
      access(1, ($urandom % 4 == 0) ? AW'($urandom) : a, 8'($urandom));
    end
  endtask

  initial begin
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < DEPTH; a++) begin ram[p][a] = 0; rm[p][a] = 0; end
    pl_rdata = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_stb = 0; acc_we = 0; acc_addr = 0; acc_wdata = 0;
    idle(3);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(acc_rvalid == 0, "R1", acc_rvalid, 0);
    check(pl_we == 0 && pl_re == 0, "R1", {pl_re, pl_we}, 0);
    check(main_sel == 0, "R1", main_sel, 0);
    @(posedge clk); #1 acc_stb = 1; acc_we = 1; acc_addr = 3; acc_wdata = 8'hFF;
    @(negedge clk);
    check(main_sel == 1 && pl_we == 0, "R1", {main_sel, pl_we}, 8);
    @(posedge clk); #1 acc_stb = 0;
    // R1: latches zero, seen through a restore write
    cfg(1, 8'h90);
    access(1, 6'd9, 8'h5A);
    idle(1);
    check(ram[0][9] == 0 && ram[1][9] == 0 && ram[2][9] == 0, "R1", ram[0][9], 0);

    // R10: fill planes through set/flip ops on zero latches
    cur_req = "R10";
    cfg(0, 8'b00_10_01_01);
    cfg(1, 8'h80);
    for (int a = 0; a < DEPTH; a++) access(1, AW'(a), 8'($urandom));
    cfg(0, 8'b00_01_11_11);
    for (int a = 0; a < DEPTH; a += 2) access(1, AW'(a), 8'($urandom));

    // R10: memory still old in the strobe cycle, new after the edge
    access(0, 6'd12, 8'h00);
    cfg(0, 8'b00_10_10_10);
    @(posedge clk); #1 acc_stb = 1; acc_we = 1; acc_addr = 12; acc_wdata = 8'hFF;
    @(negedge clk);
    check(ram[0][12] == rl[0], "R10", ram[0][12], rl[0]);
    @(posedge clk); #1 acc_stb = 0;
    @(negedge clk);
    check(ram[0][12] == (rl[0] ^ 8'hFF), "R10", ram[0][12], rl[0] ^ 8'hFF);

    cur_req = "R2 R3"; round(0, 120);
    cur_req = "R4";    round(1, 60);
    cur_req = "R5";    round(2, 60);
    cur_req = "R6";    round(3, 60);

    // R8: directed matches on known bytes
    cur_req = "R8";
    cfg(0, 8'h00);
    cfg(1, 8'h80);
    access(0, 6'd20, 8'h00);
    access(1, 6'd20, 8'hFF);          // all planes cleared
    cfg(1, 8'h80);
    access(0, 6'd20, 8'h00);          // ref 000 -> all ones
    cfg(1, 8'h87);
    access(0, 6'd20, 8'h00);          // ref 111 -> all zeros
    for (int i = 0; i < 40; i++) begin
      cfg(1, {5'b10000, 3'($urandom)});
      access(0, AW'($urandom), 8'h00);
    end

    // R9: main-memory accesses leave planes and latches alone
    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      cfg(1, 8'h90);
      access(0, a, 8'h00);
      cfg(1, 8'h10);
      access(0, AW'($urandom), 8'h00);
      access(1, AW'($urandom), 8'($urandom));
      cfg(1, 8'h90);
      access(1, AW'($urandom), 8'h00);  // restore exposes unchanged latches
    end

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog (R1..all): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule